// File: doc/BRIEF.md
# TCP Splice Sequence Number Translator

A content-aware switch first answers the client's handshake using an initial sequence number of its own. It then opens a second connection to a server, and that server picks an independent initial sequence number. When the two connections are joined, every header that crosses the switch has to be moved between these two sequence spaces. This block keeps a small table that maps each spliced connection to the signed offset between the switch's number and the server's number. It rewrites one 32-bit field per header and adjusts the TCP checksum to match.

Headers coming from the client keep their sequence number, because the switch reused the client's number toward the server. Only their acknowledgement is moved from the switch space into the server space. Headers coming from the server have their sequence number moved from the server space into the switch space, and their acknowledgement already refers to the client and stays as it is. Connections are found by a tag. A header whose tag is not in the table goes through unchanged and is flagged. Control logic writes an entry once both handshakes are done and drops it when either side closes or resets.

Top module: `tsx_splice_xlate`

## Requirements
- R1: After reset, out_valid is low, in_ready is high and no table entry is valid, so any header presented is flagged as a miss.
- R2: For a hit with in_dir = 0 (client to server), out_ack = in_ack − (D − S) modulo 2^32, where D is the switch number and S is the server number installed for that tag.
- R3: For in_dir = 0, out_seq equals in_seq.
- R4: For a hit with in_dir = 1 (server to client), out_seq = in_seq + (D − S) modulo 2^32 and out_ack equals in_ack.
- R5: On a hit, out_csum is the one's-complement checksum recomputed for the changed 32-bit field (high and low 16-bit halves), equal to the checksum of the same header with the new field value.
- R6: On a miss, out_seq, out_ack and out_csum equal the inputs and out_miss is 1. On a hit, out_miss is 0.
- R7: A pulse on inv_en clears every valid entry whose tag equals inv_tag. Headers with that tag then miss.
- R8: A pulse on ins_en writes tag, D and S into slot ins_idx and replaces what was there. When several valid slots carry the same tag, the lowest-numbered slot is used. Table writes affect headers accepted from the next cycle on.
- R9: Offsets wrap modulo 2^32 in both directions.
- R10: A header accepted at a rising edge (in_valid and in_ready) appears on the outputs with out_valid high after that edge. While out_valid is high and out_ready is low, the outputs hold and in_ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header present |
| in_ready | output | 1 | Header accepted this cycle |
| in_tag | input | TAG_W | Connection tag |
| in_dir | input | 1 | 0 client to server, 1 server to client |
| in_seq | input | 32 | Sequence number |
| in_ack | input | 32 | Acknowledgement number |
| in_csum | input | 16 | TCP checksum |
| out_valid | output | 1 | Rewritten header present |
| out_ready | input | 1 | Consumer takes the header |
| out_seq | output | 32 | Rewritten sequence number |
| out_ack | output | 32 | Rewritten acknowledgement number |
| out_csum | output | 16 | Adjusted checksum |
| out_miss | output | 1 | Tag not found, header passed unchanged |
| ins_en | input | 1 | Install strobe |
| ins_idx | input | IDX_W | Slot to write |
| ins_tag | input | TAG_W | Tag to store |
| ins_dnum | input | 32 | Switch initial sequence number D |
| ins_snum | input | 32 | Server initial sequence number S |
| inv_en | input | 1 | Invalidate strobe |
| inv_tag | input | TAG_W | Tag to drop |

## Verification
The bench sends headers in both directions on a hit. This shows whether the offset is added to the sequence field, subtracted from the acknowledgement field, and whether the untouched field is left alone. Offsets chosen so that D − S wraps past 2^32 show whether the arithmetic is modular. Checksums are built from a known sum of the rest of the header, so a wrong adjustment is caught exactly. Further cases cover unknown tags, tags installed twice, overwritten slots, invalidated tags and output back-pressure. These show that lookups use the lowest slot, that a miss leaves the header intact, and that held outputs do not change.

// File: rtl/tsx_pkg.sv
package tsx_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned CSUM_W = 16;

    typedef enum logic {
        DIR_C2S = 1'b0,
        DIR_S2C = 1'b1
    } dir_e;

    typedef struct packed {
        logic              valid;
        logic              miss;
        logic [WORD_W-1:0] seq;
        logic [WORD_W-1:0] ack;
        logic [CSUM_W-1:0] csum;
    } out_t;
endpackage

// File: rtl/tsx_conn_table.sv
module tsx_conn_table #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned TAG_W   = 16,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] look_tag,
    output logic             look_hit,
    output logic [31:0]      look_delta,
    input  logic             ins_en,
    input  logic [IDX_W-1:0] ins_idx,
    input  logic [TAG_W-1:0] ins_tag,
    input  logic [31:0]      ins_dnum,
    input  logic [31:0]      ins_snum,
    input  logic             inv_en,
    input  logic [TAG_W-1:0] inv_tag
);
    logic [ENTRIES-1:0] vld_d, vld_q;
    logic [TAG_W-1:0]   tag_d [ENTRIES];
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [31:0]        dlt_d [ENTRIES];
    logic [31:0]        dlt_q [ENTRIES];
    logic [ENTRIES-1:0] inv_match;

    always_comb begin
        vld_d = vld_q;
        for (int i = 0; i < ENTRIES; i++) begin
            tag_d[i]     = tag_q[i];
            dlt_d[i]     = dlt_q[i];
            inv_match[i] = (tag_q[i] == inv_tag);
            if (inv_en && inv_match[i]) vld_d[i] = 1'b0;
            if (ins_en && ins_idx == IDX_W'(i)) begin
                vld_d[i] = 1'b1;
                tag_d[i] = ins_tag;
                dlt_d[i] = ins_dnum - ins_snum;
            end
        end
        look_hit   = 1'b0;
        look_delta = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (vld_q[i] && tag_q[i] == look_tag) begin
                look_hit   = 1'b1;
                look_delta = dlt_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
        for (int i = 0; i < ENTRIES; i++) begin
            tag_q[i] <= tag_d[i];
            dlt_q[i] <= dlt_d[i];
        end
    end

    // R7: invalidated tags leave no valid slot behind unless a same-cycle install
    p_inval_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !ins_en) |=> ((vld_q & $past(inv_match)) == '0));
    // R8: an installed slot becomes valid
    p_install_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |=> vld_q[$past(ins_idx)]);
endmodule

// File: rtl/tsx_csum_adj.sv
module tsx_csum_adj (
    input  logic [15:0] old_csum,
    input  logic [31:0] old_word,
    input  logic [31:0] new_word,
    output logic [15:0] new_csum
);
    logic [19:0] acc;
    logic [16:0] fold1;
    logic [16:0] fold2;

    always_comb begin
        acc = {4'd0, ~old_csum} + {4'd0, ~old_word[31:16]} + {4'd0, ~old_word[15:0]}
            + {4'd0, new_word[31:16]} + {4'd0, new_word[15:0]};
        fold1 = {1'b0, acc[15:0]} + {13'd0, acc[19:16]};
        fold2 = {1'b0, fold1[15:0]} + {16'd0, fold1[16]};
        new_csum = ~fold2[15:0];
    end
endmodule

// File: rtl/tsx_splice_xlate.sv
module tsx_splice_xlate
    import tsx_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned TAG_W   = 16,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             in_dir,
    input  logic [31:0]      in_seq,
    input  logic [31:0]      in_ack,
    input  logic [15:0]      in_csum,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_seq,
    output logic [31:0]      out_ack,
    output logic [15:0]      out_csum,
    output logic             out_miss,
    input  logic             ins_en,
    input  logic [IDX_W-1:0] ins_idx,
    input  logic [TAG_W-1:0] ins_tag,
    input  logic [31:0]      ins_dnum,
    input  logic [31:0]      ins_snum,
    input  logic             inv_en,
    input  logic [TAG_W-1:0] inv_tag
);
    out_t        r_d, r_q;
    logic        hit;
    logic [31:0] delta;
    logic        accept;
    logic [31:0] old_word, new_word;
    logic [15:0] adj_csum;

    tsx_conn_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .look_tag(in_tag), .look_hit(hit), .look_delta(delta),
        .ins_en(ins_en), .ins_idx(ins_idx), .ins_tag(ins_tag),
        .ins_dnum(ins_dnum), .ins_snum(ins_snum),
        .inv_en(inv_en), .inv_tag(inv_tag)
    );

    tsx_csum_adj u_csum (
        .old_csum(in_csum), .old_word(old_word),
        .new_word(new_word), .new_csum(adj_csum)
    );

    assign in_ready = !r_q.valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        if (dir_e'(in_dir) == DIR_C2S) begin
            old_word = in_ack;
            new_word = in_ack - delta;
        end else begin
            old_word = in_seq;
            new_word = in_seq + delta;
        end

        r_d = r_q;
        if (out_ready) r_d.valid = 1'b0;
        if (accept) begin
            r_d.valid = 1'b1;
            r_d.miss  = !hit;
            r_d.seq   = in_seq;
            r_d.ack   = in_ack;
            r_d.csum  = in_csum;
            if (hit) begin
                r_d.csum = adj_csum;
                if (dir_e'(in_dir) == DIR_C2S) r_d.ack = new_word;
                else                           r_d.seq = new_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_valid = r_q.valid;
    assign out_miss  = r_q.miss;
    assign out_seq   = r_q.seq;
    assign out_ack   = r_q.ack;
    assign out_csum  = r_q.csum;

    // R10: held output under back-pressure
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_seq) && $stable(out_ack)
                                      && $stable(out_csum) && $stable(out_miss)));
    // R10: accepted header shows up on the next cycle
    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    // R3: client-side sequence passes untouched
    p_c2s_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_dir) |=> (out_seq == $past(in_seq)));
    // R4: server-side acknowledgement passes untouched
    p_s2c_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_dir) |=> (out_ack == $past(in_ack)));
    // R6: a miss leaves all fields intact
    p_miss_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit) |=> (out_miss && out_seq == $past(in_seq)
                              && out_ack == $past(in_ack) && out_csum == $past(in_csum)));
endmodule

// File: tb/tsx_splice_xlate_tb.sv
module tsx_splice_xlate_tb;
    localparam int ENTRIES = 16;
    localparam int TAG_W   = 16;
    localparam int IDX_W   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready, in_dir = 1'b0;
    logic [TAG_W-1:0] in_tag = '0;
    logic [31:0] in_seq = '0, in_ack = '0;
    logic [15:0] in_csum = '0;
    logic out_valid, out_ready = 1'b1, out_miss;
    logic [31:0] out_seq, out_ack;
    logic [15:0] out_csum;
    logic ins_en = 1'b0, inv_en = 1'b0;
    logic [IDX_W-1:0] ins_idx = '0;
    logic [TAG_W-1:0] ins_tag = '0, inv_tag = '0;
    logic [31:0] ins_dnum = '0, ins_snum = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tsx_splice_xlate #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_tag(in_tag), .in_dir(in_dir), .in_seq(in_seq), .in_ack(in_ack),
        .in_csum(in_csum), .out_valid(out_valid), .out_ready(out_ready),
        .out_seq(out_seq), .out_ack(out_ack), .out_csum(out_csum),
        .out_miss(out_miss), .ins_en(ins_en), .ins_idx(ins_idx),
        .ins_tag(ins_tag), .ins_dnum(ins_dnum), .ins_snum(ins_snum),
        .inv_en(inv_en), .inv_tag(inv_tag)
    );

    localparam logic [31:0] REST = 32'h0003_A5C7;

    function automatic logic [15:0] fold(input logic [31:0] v);
        logic [31:0] x;
        x = v;
        while (x[31:16] != 0) x = {16'd0, x[15:0]} + {16'd0, x[31:16]};
        return x[15:0];
    endfunction

    function automatic logic [15:0] csum_of(input logic [31:0] w);
        return ~fold(REST + {16'd0, w[31:16]} + {16'd0, w[15:0]});
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic install(input int idx, input logic [TAG_W-1:0] t,
                           input logic [31:0] d, input logic [31:0] s);
        @(negedge clk);
        ins_en = 1'b1; ins_idx = IDX_W'(idx); ins_tag = t; ins_dnum = d; ins_snum = s;
        @(negedge clk);
        ins_en = 1'b0;
    endtask

    task automatic invalidate(input logic [TAG_W-1:0] t);
        @(negedge clk);
        inv_en = 1'b1; inv_tag = t;
        @(negedge clk);
        inv_en = 1'b0;
    endtask

    // sends one header; the csum supplied covers the field that may be rewritten
    task automatic send(input logic [TAG_W-1:0] t, input logic dir,
                        input logic [31:0] s, input logic [31:0] a);
        @(negedge clk);
        in_valid = 1'b1; in_tag = t; in_dir = dir; in_seq = s; in_ack = a;
        in_csum = dir ? csum_of(s) : csum_of(a);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1 in_ready", {31'd0, in_ready}, 32'd1);
        send(16'h0000, 1'b0, 32'h11, 32'h22);
        chk("R1 miss", {31'd0, out_miss}, 32'd1);
    endtask

    task automatic t_c2s();
        logic [31:0] d = 32'h1000_0000, s = 32'hF000_0010;
        install(3, 16'h00A1, d, s);
        send(16'h00A1, 1'b0, 32'h7777_0001, d + 32'd101);
        chk("R10 out_valid", {31'd0, out_valid}, 32'd1);
        chk("R6 hit", {31'd0, out_miss}, 32'd0);
        chk("R2 ack", out_ack, s + 32'd101);
        chk("R3 seq", out_seq, 32'h7777_0001);
        chk("R5 csum c2s", {16'd0, out_csum}, {16'd0, csum_of(s + 32'd101)});
    endtask

    task automatic t_s2c();
        logic [31:0] d = 32'h1000_0000, s = 32'hF000_0010;
        send(16'h00A1, 1'b1, s + 32'd1, 32'h5555_1234);
        chk("R4 seq", out_seq, d + 32'd1);
        chk("R4 ack", out_ack, 32'h5555_1234);
        chk("R5 csum s2c", {16'd0, out_csum}, {16'd0, csum_of(d + 32'd1)});
    endtask

    task automatic t_wrap();
        logic [31:0] d = 32'hFFFF_FFF0, s = 32'h0000_0010;
        install(7, 16'h0B0B, d, s);
        send(16'h0B0B, 1'b1, 32'h30, 32'h1);
        chk("R9 s2c wrap", out_seq, 32'h0000_0010);
        send(16'h0B0B, 1'b0, 32'h2, 32'h0000_0005);
        chk("R9 c2s wrap", out_ack, 32'h0000_0025);
    endtask

    task automatic t_miss();
        send(16'h0999, 1'b1, 32'hABCD_0000, 32'h1234_5678);
        chk("R6 miss flag", {31'd0, out_miss}, 32'd1);
        chk("R6 seq", out_seq, 32'hABCD_0000);
        chk("R6 ack", out_ack, 32'h1234_5678);
        chk("R6 csum", {16'd0, out_csum}, {16'd0, csum_of(32'hABCD_0000)});
    endtask

    task automatic t_dup_overwrite_inval();
        install(5, 16'h0C0C, 32'h0000_1000, 32'h0000_0000);
        install(2, 16'h0C0C, 32'h0000_2000, 32'h0000_0000);
        send(16'h0C0C, 1'b1, 32'h1, 32'h0);
        chk("R8 lowest slot", out_seq, 32'h0000_2001);
        install(2, 16'h0D0D, 32'h0000_3000, 32'h0000_0000);
        send(16'h0C0C, 1'b1, 32'h1, 32'h0);
        chk("R8 overwrite", out_seq, 32'h0000_1001);
        send(16'h0D0D, 1'b1, 32'h1, 32'h0);
        chk("R8 new tag", out_seq, 32'h0000_3001);
        install(9, 16'h0C0C, 32'h0000_4000, 32'h0000_0000);
        invalidate(16'h0C0C);
        send(16'h0C0C, 1'b1, 32'h1, 32'h0);
        chk("R7 inval miss", {31'd0, out_miss}, 32'd1);
        chk("R7 inval seq", out_seq, 32'h1);
        send(16'h0D0D, 1'b1, 32'h1, 32'h0);
        chk("R7 other kept", out_seq, 32'h0000_3001);
    endtask

    task automatic t_backpressure();
        @(negedge clk);
        out_ready = 1'b0;
        send(16'h00A1, 1'b1, 32'hF000_0011, 32'h9);
        chk("R10 bp valid", {31'd0, out_valid}, 32'd1);
        chk("R10 bp ready", {31'd0, in_ready}, 32'd0);
        in_valid = 1'b1; in_tag = 16'h0999; in_dir = 1'b0;
        in_seq = 32'hDEAD_0000; in_ack = 32'hBEEF_0000;
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk("R10 bp hold", out_seq, 32'h1000_0001);
        chk("R10 bp miss", {31'd0, out_miss}, 32'd0);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 next", out_seq, 32'hDEAD_0000);
        chk("R10 next miss", {31'd0, out_miss}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_c2s();
        t_s2c();
        t_wrap();
        t_miss();
        t_dup_overwrite_inval();
        t_backpressure();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule